// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block holds a bank of one-time-programmable protection registers together with the two lock words that guard them. It presents one 16-bit word interface. Software selects a word by its offset. While the read-identifier mode flag is high, the word at that offset appears on the read port one clock later. A program strobe merges write data into the selected word. Storage follows an active-low convention: 1 means erased and 0 means programmed. A program can therefore only clear bits and can never set them again.

Register 0 has two halves. The lower half holds a unique identifier that is preset at power-on and locked from the start. The upper half is free for user data. Registers 1 to 16 are each guarded by one bit of a second lock word. The lock words are one-time-programmable in the same way, so a register that has been locked stays locked.

A program aimed outside the protection window, or at a locked word, changes nothing and raises sticky error flags in an 8-bit status output. The flags stay set until the clear-status input is pulsed. Reset models power-on: it loads the erased image, the identifier and the factory lock bit.

Top module: `otp_prot_regs`

## Requirements
- R1: After reset:
  - status is 0x00;
  - every user data word reads 0xFFFF;
  - the first lock word (offset 0x80) reads 0xFFFE;
  - the second lock word (offset 0x89) reads 0xFFFF;
  - identifier word k (offset 0x81+k, k=0..3) reads bits 16k+15..16k of ID_VALUE.
- R2: While idMode is high, rdData in the cycle after a clock edge equals the stored word at the offset that addr held at that edge. Offsets outside 0x080..0x109 read 0xFFFF.
- R3: While idMode is low at a clock edge, rdData after that edge is 0xFFFF whatever addr holds.
- R4: A program of an unlocked data word stores old AND wrData. A bit never returns from 0 to 1. The same word may be programmed again to clear further bits, and no status bit is set.
- R5: A program at an offset below 0x080 or above 0x109 sets status bit 4 (program error), leaves status bit 1 clear and changes no stored word.
- R6: A program of a locked data word sets status bits 4 and 1 and leaves the word unchanged. The identifier words 0x81..0x84 are locked from reset by bit 0 of the first lock word.
- R7: A data word is locked when its lock bit is 0:
  - bit 1 of the first lock word locks offsets 0x85..0x88;
  - bit k (k=0..15) of the second lock word locks register k+1 at offsets 0x8A+8k..0x91+8k.
- R8: A program of either lock word stores old AND wrData and never raises an error. A lock bit once cleared cannot be set again, so a locked register stays locked.
- R9: Status error bits are sticky:
  - a later successful program does not clear them;
  - a clrStatus pulse clears them at the next edge;
  - when clrStatus and an error happen in the same cycle, the error bits end up set.
- R10: Data word offsets map as follows: register 0 at 0x81..0x88, register r (r=1..16) at 0x8A+8(r-1)..0x91+8(r-1). The last word sits at 0x109.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset (power-on image load) |
| idMode | input | 1 | Read-identifier mode; enables reads |
| addr | input | 9 | Word offset for read and program |
| progReq | input | 1 | One-cycle program strobe |
| wrData | input | 16 | Program data, AND-merged into the addressed word |
| clrStatus | input | 1 | Clears the sticky error bits |
| rdData | output | 16 | Registered read word |
| status | output | 8 | Bit 4 program error, bit 1 lock error, other bits 0 |

## Verification
The bench builds the block with its default parameters: 17 registers of 128 bits, 16-bit words and a 9-bit offset, so the whole 512-offset space is only a few hundred cycles per sweep. That size makes full read sweeps of every offset possible after each phase, as well as programming every data word twice with two arithmetic patterns. Every locking combination the bench sets up is then checked against a model that the bench keeps. Out-of-window offsets on both sides, the identifier segment, the last register, writes to a lock word that try to raise its bits, and the clear/error collision are all aimed at directly.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WIDX_W = 8;
  localparam int STAT_W = 8;
  localparam int STAT_PRG_BIT = 4;
  localparam int STAT_LOCK_BIT = 1;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LOCK0 = 2'd1,
    SEL_LOCK1 = 2'd2,
    SEL_WORD  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic              wrWord;
    logic              wrLock0;
    logic              wrLock1;
    logic              setPrgErr;
    logic              setLockErr;
    logic              clrErr;
    logic              rdEn;
    rdSel_e            rdSel;
    logic [WIDX_W-1:0] wordIdx;
  } otpStrobe_t;
endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 17,
  parameter int WPR = 8,
  parameter logic [ADDR_W-1:0] BASE = 9'h080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              progReq,
  input  logic              clrStatus,
  input  logic              idMode,
  input  logic [1:0]        lockSeg,
  input  logic [DATA_W-1:0] lock1,
  output otpStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] TOTAL_OFF = ADDR_W'(NUM_REGS * WPR + 2);
  localparam logic [ADDR_W-1:0] LOCK1_OFF = ADDR_W'(WPR + 1);
  localparam logic [WIDX_W-1:0] HALF_IDX  = WIDX_W'(WPR / 2);
  localparam int SEG_SHIFT = $clog2(WPR);

  logic [ADDR_W-1:0] off;
  logic              inRange, isLock0, isLock1, isWord, locked;
  logic [WIDX_W-1:0] idx, regNum;
  logic [DATA_W-1:0] regMask;

  always_comb begin
    off     = addr - BASE;
    inRange = (addr >= BASE) && (off < TOTAL_OFF);
    isLock0 = inRange && (off == '0);
    isLock1 = inRange && (off == LOCK1_OFF);
    isWord  = inRange && !isLock0 && !isLock1;
    idx     = (off < LOCK1_OFF) ? WIDX_W'(off - ADDR_W'(1)) : WIDX_W'(off - ADDR_W'(2));
    regNum  = idx >> SEG_SHIFT;
    regMask = DATA_W'(1) << (regNum - WIDX_W'(1));
    if (regNum == '0) locked = (idx < HALF_IDX) ? !lockSeg[0] : !lockSeg[1];
    else              locked = |(regMask & ~lock1);
  end

  always_comb begin
    strb            = '0;
    strb.wordIdx    = idx;
    strb.wrWord     = progReq && isWord && !locked;
    strb.wrLock0    = progReq && isLock0;
    strb.wrLock1    = progReq && isLock1;
    strb.setPrgErr  = progReq && (!inRange || (isWord && locked));
    strb.setLockErr = progReq && isWord && locked;
    strb.clrErr     = clrStatus;
    strb.rdEn       = idMode;
    if (!inRange)     strb.rdSel = SEL_NONE;
    else if (isLock0) strb.rdSel = SEL_LOCK0;
    else if (isLock1) strb.rdSel = SEL_LOCK1;
    else              strb.rdSel = SEL_WORD;
  end

  // R5: a program takes at most one action
  assert_one_action_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrWord, strb.wrLock0, strb.wrLock1, strb.setPrgErr}));

  // R5: below the window only a program error results
  assert_below_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && addr < BASE) |-> (strb.setPrgErr && !strb.setLockErr && !strb.wrWord));

  // R6: identifier words can never be written while lock bit 0 is clear
  assert_id_guard_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!lockSeg[0] && strb.wordIdx < HALF_IDX && strb.rdSel == SEL_WORD) |-> !strb.wrWord);
endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_WORDS = 136,
  parameter int WPR = 8,
  parameter int ID_W = 64,
  parameter logic [ID_W-1:0] ID_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  otpStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        lockSeg,
  output logic [DATA_W-1:0] lock1,
  output logic [STAT_W-1:0] status
);
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int HALF = WPR / 2;
  localparam logic [DATA_W-1:0] LOCK0_INIT = {{(DATA_W-1){1'b1}}, 1'b0};

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic [DATA_W-1:0] lock0;
  logic              prgErr, lockErr;
  logic [IDX_W-1:0]  idx;

  function automatic logic [DATA_W-1:0] initWord(int i);
    if (i < HALF) return ID_VALUE[i*DATA_W +: DATA_W];
    return '1;
  endfunction

  assign idx = strb.wordIdx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= initWord(i);
    end else if (strb.wrWord) begin
      mem[idx] <= mem[idx] & wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lock0 <= LOCK0_INIT;
      lock1 <= '1;
    end else begin
      if (strb.wrLock0) lock0 <= lock0 & wrData;
      if (strb.wrLock1) lock1 <= lock1 & wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prgErr  <= 1'b0;
      lockErr <= 1'b0;
    end else begin
      if (strb.setPrgErr)   prgErr <= 1'b1;
      else if (strb.clrErr) prgErr <= 1'b0;
      if (strb.setLockErr)  lockErr <= 1'b1;
      else if (strb.clrErr) lockErr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '1;
    else if (!strb.rdEn) rdData <= '1;
    else begin
      case (strb.rdSel)
        SEL_LOCK0: rdData <= lock0;
        SEL_LOCK1: rdData <= lock1;
        SEL_WORD:  rdData <= mem[idx];
        default:   rdData <= '1;
      endcase
    end
  end

  assign lockSeg = lock0[1:0];

  always_comb begin
    status = '0;
    status[STAT_PRG_BIT]  = prgErr;
    status[STAT_LOCK_BIT] = lockErr;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_wordChk
    // R4: a stored bit never returns from 0 to 1
    assert_word_no_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
      (mem[g] & ~$past(mem[g])) == '0);
    if (g < HALF) begin : g_idChk
      // R6: identifier words never change
      assert_id_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
        $stable(mem[g]));
    end
  end

  // R8: lock bits are one-time-programmable
  assert_lock_no_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((lock0 & ~$past(lock0)) == '0) && ((lock1 & ~$past(lock1)) == '0));

  // R9: error flag holds unless cleared
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(prgErr) && !$past(strb.clrErr)) |-> prgErr);

  // R6: a lock error always comes with a program error
  assert_lockerr_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |-> prgErr);

  // R3: reads outside identifier mode return all ones
  assert_idle_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.rdEn) |-> (rdData == '1));
endmodule

// File: rtl/otp_prot_regs.sv
module otp_prot_regs
  import otp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_BITS = 128,
  parameter int NUM_REGS = 17,
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE = 9'h080,
  parameter logic [REG_BITS/2-1:0] ID_VALUE = 64'hC3A5_0F1E_7B24_9D68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              progReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic              clrStatus,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] status
);
  localparam int WPR = REG_BITS / DATA_W;
  localparam int NUM_WORDS = NUM_REGS * WPR;

  otpStrobe_t        strb;
  logic [1:0]        lockSeg;
  logic [DATA_W-1:0] lock1;

  otp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .WPR(WPR), .BASE(BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .progReq(progReq), .clrStatus(clrStatus),
    .idMode(idMode), .lockSeg(lockSeg), .lock1(lock1), .strb(strb)
  );

  otp_datapath #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .WPR(WPR), .ID_W(REG_BITS/2), .ID_VALUE(ID_VALUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .lockSeg(lockSeg), .lock1(lock1), .status(status)
  );
endmodule

// File: tb/otp_prot_regs_bench.sv
module otp_prot_regs_bench;
  localparam logic [63:0] ID = 64'hC3A5_0F1E_7B24_9D68;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        idMode = 1'b0;
  logic [8:0]  addr = '0;
  logic        progReq = 1'b0;
  logic [15:0] wrData = '0;
  logic        clrStatus = 1'b0;
  logic [15:0] rdData;
  logic [7:0]  status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] expMem [136];
  logic [15:0] expL0, expL1;
  logic        expPrg, expLk;

  always #2.5 clk = ~clk;

  otp_prot_regs u_otp_prot_regs (
    .clk(clk), .rstN(rstN), .idMode(idMode), .addr(addr), .progReq(progReq),
    .wrData(wrData), .clrStatus(clrStatus), .rdData(rdData), .status(status)
  );

  // -1 outside window, -2 first lock word, -3 second lock word, else data index
  function automatic int kindOf(int a);
    int off;
    if (a < 'h80 || a > 'h109) return -1;
    off = a - 'h80;
    if (off == 0) return -2;
    if (off == 9) return -3;
    return (off < 9) ? off - 1 : off - 2;
  endfunction

  function automatic bit isLocked(int i);
    if (i < 4) return !expL0[0];
    if (i < 8) return !expL0[1];
    return !expL1[i/8 - 1];
  endfunction

  function automatic logic [15:0] expRead(int a);
    int k;
    k = kindOf(a);
    if (k == -1) return 16'hFFFF;
    if (k == -2) return expL0;
    if (k == -3) return expL1;
    return expMem[k];
  endfunction

  function automatic logic [7:0] expStat();
    return {3'b000, expPrg, 2'b00, expLk, 1'b0};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readChk(int a, string req);
    idMode = 1'b1; progReq = 1'b0; addr = 9'(a);
    @(posedge clk); #1;
    check(req, rdData, expRead(a));
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 512; a++) readChk(a, req);
  endtask

  task automatic prog(int a, logic [15:0] d, string req);
    int k;
    addr = 9'(a); wrData = d; progReq = 1'b1;
    @(posedge clk); #1;
    progReq = 1'b0;
    k = kindOf(a);
    if (k == -1) expPrg = 1'b1;
    else if (k == -2) expL0 = expL0 & d;
    else if (k == -3) expL1 = expL1 & d;
    else if (isLocked(k)) begin expPrg = 1'b1; expLk = 1'b1; end
    else expMem[k] = expMem[k] & d;
    check(req, {8'h00, status}, {8'h00, expStat()});
  endtask

  task automatic clr();
    clrStatus = 1'b1;
    @(posedge clk); #1;
    clrStatus = 1'b0;
    expPrg = 1'b0; expLk = 1'b0;
    check("R9 clear", {8'h00, status}, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 136; i++) expMem[i] = (i < 4) ? ID[16*i +: 16] : 16'hFFFF;
    expL0 = 16'hFFFE; expL1 = 16'hFFFF; expPrg = 0; expLk = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 reset status", {8'h00, status}, 16'h0000);
    sweep("R1 R2 R10 reset sweep");

    // R3: reads with idMode low
    idMode = 1'b0;
    for (int a = 'h7E; a < 'h8C; a++) begin
      addr = 9'(a); @(posedge clk); #1;
      check("R3 idle read", rdData, 16'hFFFF);
    end

    // R4 R6 R10: program every data offset with first pattern
    for (int a = 'h81; a <= 'h109; a++) if (kindOf(a) >= 0) begin
      prog(a, 16'(a * 16'h03D7) ^ 16'h5A5A, "R4 R6 program pass 1");
      if (expPrg) clr();
    end
    sweep("R4 R10 after pass 1");

    // R4: second program clears more bits
    for (int a = 'h85; a <= 'h109; a++) if (kindOf(a) >= 0) begin
      prog(a, ~(16'h0001 << (a % 16)) & 16'hF7FF, "R4 program pass 2");
      if (expPrg) clr();
    end
    sweep("R4 after pass 2");

    // R5: outside the window
    prog('h000, 16'h0000, "R5 out low");  clr();
    prog('h07F, 16'h0000, "R5 out edge low"); clr();
    prog('h10A, 16'h0000, "R5 out edge high"); clr();
    prog('h1FF, 16'h0000, "R5 out top"); clr();
    sweep("R5 no change");

    // R7 R8: lock user half of reg0, reg1 and reg16
    prog('h80, 16'hFFFD, "R8 lock0 program");
    prog('h89, 16'h7FFE, "R8 lock1 program");
    prog('h85, 16'h0000, "R7 R6 reg0 user locked"); clr();
    prog('h88, 16'h0000, "R7 R6 reg0 user end locked"); clr();
    prog('h8A, 16'h0000, "R7 R6 reg1 locked"); clr();
    prog('h91, 16'h0000, "R7 R6 reg1 end locked"); clr();
    prog('h109, 16'h0000, "R7 R6 reg16 locked"); clr();
    prog('h92, 16'h00F0, "R7 reg2 free");
    prog('h101, 16'h0F00, "R7 reg15 free");
    prog('h81, 16'h0000, "R6 id locked"); clr();
    // R8: lock bits cannot return to 1
    prog('h89, 16'hFFFF, "R8 lock1 raise attempt");
    prog('h80, 16'hFFFF, "R8 lock0 raise attempt");
    readChk('h89, "R8 lock1 readback");
    readChk('h80, "R8 lock0 readback");
    sweep("R7 R8 after locking");

    // R9: sticky through success, collision keeps set
    prog('h000, 16'h1234, "R9 error set");
    prog('h93, 16'hFFEF, "R9 sticky through success");
    clrStatus = 1'b1;
    prog('h1F0, 16'h0000, "R9 clear collides with error");
    clrStatus = 1'b0;
    check("R9 collision result", {8'h00, status}, 16'h0010);
    clr();
    sweep("R2 final sweep");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule